// File: doc/BRIEF.md
# Serial GPIO expander controller

This block adds up to 128 general-purpose I/O bits to a chip using only four pins. The pins are a shift clock, a load strobe, serial data out and serial data in, and they connect to a chain of external shift registers. The controller runs frames back to back. In each frame it shifts the output values into the chain and samples the chain's input values on the same clock. It then pulses the load strobe, which makes the external registers present the new outputs and capture fresh inputs.

The stream is built from 32 ports. Every enabled port carries the same number of bits, from 1 to 4, and a 32-bit enable mask removes unused ports from the stream completely, so a short chain still gets a short frame. GPIO number `4*port + bit` is the bit `bit` of port `port`. Each GPIO has a polarity bit that inverts both the value driven and the value sampled. A divider sets the shift rate from the block clock. Software uses a small word-addressed register port to enable the controller, set the stream shape, write the outputs and read back the captured inputs.

Top module: `serial_gpio_expander`

## Requirements
- R1: After reset the control word (address 0) reads 0, the divider (address 1) reads 0, the port mask (address 2) reads 0xFFFFFFFF, all output, polarity and input words read 0, and the shift clock and load strobe are low.
- R2: While the enable bit (address 0, bit 0) is 0, the shift clock and the load strobe stay low and no frame is sent.
- R3: Within a frame, bits leave in ascending port order, and inside each port in ascending bit index. The bit sent for GPIO n is output word n/32 (addresses 4 to 7), bit n%32, and it is sampled by the external chain on the rising shift-clock edge.
- R4: A port whose mask bit (address 2, bit p) is 0 contributes no bits. With a mask of zero, frames contain no shift-clock edges but the load strobe still pulses.
- R5: Address 0 bits [2:1] hold the bits per port minus one (0 to 3 give 1 to 4 bits), and every enabled port sends that many bits.
- R6: A polarity bit of 1 (addresses 8 to 11, same bit layout as the output words) inverts the serial level driven for that GPIO.
- R7: A polarity bit of 1 inverts the value stored for that GPIO's sampled input.
- R8: Each high phase and each low phase of the shift clock lasts divider+1 block-clock cycles.
- R9: Serial data out changes only while the shift clock is low. The controller changes it together with the falling edge and samples serial data in at the rising edge.
- R10: After the last bit of a frame the load strobe stays high for 2*(divider+1) cycles with the shift clock low. The next frame then starts on its own.
- R11: The input words (addresses 12 to 15, read-only) update all at once at the end of each frame. GPIOs that are not part of the stream read 0.
- R12: The control, divider, mask, output and polarity registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block (reference) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sio_clk | output | 1 | Shift clock to the external chain |
| sio_ld | output | 1 | Load strobe to the external chain |
| sio_do | output | 1 | Serial data to the chain |
| sio_di | input | 1 | Serial data from the chain |

## Verification
The bench models the external chain and tests sparse masks: ports 0, 2 and 31 only, a checkerboard pattern, and an all-zero mask. A scan that failed to skip disabled ports would produce frames that are too long, or bits assigned to the wrong GPIO. An empty mask must still give load pulses and all-zero inputs; a design that stalled or kept stale data would show up there. Polarity is set to non-zero values on both directions, so an inversion applied only on output, or applied twice, changes the frame or the readback. The bench measures the divider-derived phase and load widths at several divider values, which catches off-by-one counting. It also covers bits-per-port values of 1, 2, 3 and 4, where a wrong end-of-port test would shift every later bit.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_GAP   = 2'd2,
    SEQ_LOAD  = 2'd3
  } seq_state_e;

  // Word addresses of the register port
  localparam logic [3:0] ADR_CTRL     = 4'd0;
  localparam logic [3:0] ADR_DIV      = 4'd1;
  localparam logic [3:0] ADR_MASK     = 4'd2;
  localparam logic [1:0] GRP_OUT      = 2'd1;  // addresses 4..7
  localparam logic [1:0] GRP_POL      = 2'd2;  // addresses 8..11
  localparam logic [1:0] GRP_IN       = 2'd3;  // addresses 12..15

endpackage

// File: rtl/sgx_clkdiv.sv
module sgx_clkdiv #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == div);
  assign tick = active && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!active || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sgx_regs.sv
module sgx_regs
  import sgx_pkg::*;
#(
  parameter int unsigned GPIO_W    = 128,
  parameter int unsigned NUM_PORTS = 32,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned BPP_W     = 2,
  localparam int unsigned WORDS    = GPIO_W / 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 run,
  output logic [BPP_W-1:0]     bpp_m1,
  output logic [DIV_W-1:0]     div,
  output logic [NUM_PORTS-1:0] port_mask,
  output logic [GPIO_W-1:0]    out_bits,
  output logic [GPIO_W-1:0]    pol_bits,
  input  logic                 frame_done,
  input  logic [GPIO_W-1:0]    shadow
);

  logic                 run_q, run_d;
  logic [BPP_W-1:0]     bpp_q, bpp_d;
  logic [DIV_W-1:0]     div_q, div_d;
  logic [NUM_PORTS-1:0] mask_q, mask_d;
  logic [31:0]          out_q [WORDS];
  logic [31:0]          out_d [WORDS];
  logic [31:0]          pol_q [WORDS];
  logic [31:0]          pol_d [WORDS];
  logic [31:0]          in_q  [WORDS];
  logic [31:0]          in_d  [WORDS];

  // Scalar configuration: next state
  always_comb begin
    run_d  = run_q;
    bpp_d  = bpp_q;
    div_d  = div_q;
    mask_d = mask_q;
    if (wr_en) begin
      case (addr)
        ADR_CTRL: begin
          run_d = wdata[0];
          bpp_d = wdata[BPP_W:1];
        end
        ADR_DIV:  div_d  = wdata[DIV_W-1:0];
        ADR_MASK: mask_d = wdata[NUM_PORTS-1:0];
        default:  ;
      endcase
    end
  end

  // Per-word data registers: next state
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [1:0] WSEL = 2'(w);
    logic hit_out, hit_pol;
    assign hit_out  = wr_en && (addr[3:2] == GRP_OUT) && (addr[1:0] == WSEL);
    assign hit_pol  = wr_en && (addr[3:2] == GRP_POL) && (addr[1:0] == WSEL);
    assign out_d[w] = hit_out ? wdata : out_q[w];
    assign pol_d[w] = hit_pol ? wdata : pol_q[w];
    assign in_d[w]  = frame_done ? shadow[w*32 +: 32] : in_q[w];
    assign out_bits[w*32 +: 32] = out_q[w];
    assign pol_bits[w*32 +: 32] = pol_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bpp_q  <= '0;
      div_q  <= '0;
      mask_q <= '1;
      for (int w = 0; w < WORDS; w++) begin
        out_q[w] <= '0;
        pol_q[w] <= '0;
        in_q[w]  <= '0;
      end
    end else begin
      run_q  <= run_d;
      bpp_q  <= bpp_d;
      div_q  <= div_d;
      mask_q <= mask_d;
      for (int w = 0; w < WORDS; w++) begin
        out_q[w] <= out_d[w];
        pol_q[w] <= pol_d[w];
        in_q[w]  <= in_d[w];
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL: begin
        rdata[0]       = run_q;
        rdata[BPP_W:1] = bpp_q;
      end
      ADR_DIV:  rdata[DIV_W-1:0]     = div_q;
      ADR_MASK: rdata[NUM_PORTS-1:0] = mask_q;
      default: begin
        case (addr[3:2])
          GRP_OUT: rdata = out_q[addr[1:0]];
          GRP_POL: rdata = pol_q[addr[1:0]];
          GRP_IN:  rdata = in_q[addr[1:0]];
          default: rdata = '0;
        endcase
      end
    endcase
  end

  assign run       = run_q;
  assign bpp_m1    = bpp_q;
  assign div       = div_q;
  assign port_mask = mask_q;

endmodule

// File: rtl/sgx_frame_seq.sv
module sgx_frame_seq
  import sgx_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 32,
  parameter int unsigned MAX_BPP   = 4,
  parameter int unsigned BPP_W     = 2,
  localparam int unsigned GPIO_W   = NUM_PORTS * MAX_BPP,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS),
  localparam int unsigned IDX_W    = $clog2(GPIO_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 tick,
  input  logic [NUM_PORTS-1:0] port_mask,
  input  logic [BPP_W-1:0]     bpp_m1,
  input  logic [GPIO_W-1:0]    drive_bits,
  input  logic [GPIO_W-1:0]    pol_bits,
  input  logic                 sio_di,
  output logic                 active,
  output logic                 sio_clk,
  output logic                 sio_ld,
  output logic                 sio_do,
  output logic                 frame_done,
  output logic [GPIO_W-1:0]    shadow
);

  seq_state_e          state_q, state_d;
  logic [PORT_W-1:0]   port_q, port_d;
  logic [BPP_W-1:0]    bit_q, bit_d;
  logic                clk_q, clk_d;
  logic                ld_q, ld_d;
  logic                do_q, do_d;
  logic                half_q, half_d;
  logic [GPIO_W-1:0]   shadow_q, shadow_d;

  logic                first_ok, next_ok;
  logic [PORT_W-1:0]   first_port, next_port;
  logic [IDX_W-1:0]    cur_idx, first_idx, next_idx;
  logic                begin_frame;

  // Lowest enabled port overall, and lowest enabled port above the current one
  always_comb begin
    first_ok   = 1'b0;
    first_port = '0;
    next_ok    = 1'b0;
    next_port  = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (port_mask[p]) begin
        first_ok   = 1'b1;
        first_port = PORT_W'(p);
      end
      if (port_mask[p] && (p > int'(port_q))) begin
        next_ok   = 1'b1;
        next_port = PORT_W'(p);
      end
    end
  end

  assign cur_idx   = IDX_W'(int'(port_q) * MAX_BPP + int'(bit_q));
  assign first_idx = IDX_W'(int'(first_port) * MAX_BPP);
  assign next_idx  = IDX_W'(int'(next_port) * MAX_BPP);

  always_comb begin
    state_d     = state_q;
    port_d      = port_q;
    bit_d       = bit_q;
    clk_d       = clk_q;
    ld_d        = ld_q;
    do_d        = do_q;
    half_d      = half_q;
    shadow_d    = shadow_q;
    frame_done  = 1'b0;
    begin_frame = 1'b0;

    case (state_q)
      SEQ_IDLE: begin
        if (run) begin_frame = 1'b1;
      end
      SEQ_SHIFT: begin
        if (tick) begin
          if (!clk_q) begin
            clk_d             = 1'b1;
            shadow_d[cur_idx] = sio_di ^ pol_bits[cur_idx];
          end else begin
            clk_d = 1'b0;
            if (bit_q < bpp_m1) begin
              bit_d = bit_q + BPP_W'(1);
              do_d  = drive_bits[cur_idx + IDX_W'(1)];
            end else if (next_ok) begin
              port_d = next_port;
              bit_d  = '0;
              do_d   = drive_bits[next_idx];
            end else begin
              state_d    = SEQ_LOAD;
              ld_d       = 1'b1;
              half_d     = 1'b0;
              frame_done = 1'b1;
            end
          end
        end
      end
      SEQ_GAP: begin
        if (tick) begin
          state_d    = SEQ_LOAD;
          ld_d       = 1'b1;
          half_d     = 1'b0;
          frame_done = 1'b1;
        end
      end
      SEQ_LOAD: begin
        if (tick) begin
          if (!half_q) begin
            half_d = 1'b1;
          end else begin
            ld_d        = 1'b0;
            begin_frame = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase

    if (begin_frame) begin
      shadow_d = '0;
      half_d   = 1'b0;
      clk_d    = 1'b0;
      if (first_ok) begin
        state_d = SEQ_SHIFT;
        port_d  = first_port;
        bit_d   = '0;
        do_d    = drive_bits[first_idx];
      end else begin
        state_d = SEQ_GAP;
      end
    end

    if (!run) begin
      state_d    = SEQ_IDLE;
      clk_d      = 1'b0;
      ld_d       = 1'b0;
      do_d       = 1'b0;
      frame_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      port_q   <= '0;
      bit_q    <= '0;
      clk_q    <= 1'b0;
      ld_q     <= 1'b0;
      do_q     <= 1'b0;
      half_q   <= 1'b0;
      shadow_q <= '0;
    end else begin
      state_q  <= state_d;
      port_q   <= port_d;
      bit_q    <= bit_d;
      clk_q    <= clk_d;
      ld_q     <= ld_d;
      do_q     <= do_d;
      half_q   <= half_d;
      shadow_q <= shadow_d;
    end
  end

  assign active  = (state_q != SEQ_IDLE);
  assign sio_clk = clk_q;
  assign sio_ld  = ld_q;
  assign sio_do  = do_q;
  assign shadow  = shadow_q;

endmodule

// File: rtl/serial_gpio_expander.sv
module serial_gpio_expander #(
  parameter int unsigned NUM_PORTS = 32,
  parameter int unsigned MAX_BPP   = 4,
  parameter int unsigned DIV_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sio_clk,
  output logic        sio_ld,
  output logic        sio_do,
  input  logic        sio_di
);

  localparam int unsigned GPIO_W = NUM_PORTS * MAX_BPP;
  localparam int unsigned BPP_W  = $clog2(MAX_BPP);

  logic                 ctl_run;
  logic [BPP_W-1:0]     ctl_bpp_m1;
  logic [DIV_W-1:0]     ctl_div;
  logic [NUM_PORTS-1:0] ctl_mask;
  logic [GPIO_W-1:0]    ctl_out;
  logic [GPIO_W-1:0]    ctl_pol;
  logic [GPIO_W-1:0]    drive_bits;
  logic [GPIO_W-1:0]    shadow;
  logic                 frame_done;
  logic                 seq_active;
  logic                 tick;

  assign drive_bits = ctl_out ^ ctl_pol;

  sgx_regs #(
    .GPIO_W    (GPIO_W),
    .NUM_PORTS (NUM_PORTS),
    .DIV_W     (DIV_W),
    .BPP_W     (BPP_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .run        (ctl_run),
    .bpp_m1     (ctl_bpp_m1),
    .div        (ctl_div),
    .port_mask  (ctl_mask),
    .out_bits   (ctl_out),
    .pol_bits   (ctl_pol),
    .frame_done (frame_done),
    .shadow     (shadow)
  );

  sgx_clkdiv #(
    .DIV_W (DIV_W)
  ) u_clkdiv (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (seq_active),
    .div    (ctl_div),
    .tick   (tick)
  );

  sgx_frame_seq #(
    .NUM_PORTS (NUM_PORTS),
    .MAX_BPP   (MAX_BPP),
    .BPP_W     (BPP_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctl_run),
    .tick       (tick),
    .port_mask  (ctl_mask),
    .bpp_m1     (ctl_bpp_m1),
    .drive_bits (drive_bits),
    .pol_bits   (ctl_pol),
    .sio_di     (sio_di),
    .active     (seq_active),
    .sio_clk    (sio_clk),
    .sio_ld     (sio_ld),
    .sio_do     (sio_do),
    .frame_done (frame_done),
    .shadow     (shadow)
  );

endmodule

// File: rtl/sgx_checker.sv
module sgx_checker #(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned CNT_W = DIV_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic [DIV_W-1:0] div,
  input logic             sio_clk,
  input logic             sio_ld,
  input logic             sio_do
);

  logic [CNT_W-1:0] hi_cnt, ld_cnt;
  logic [CNT_W-1:0] phase_len;

  assign phase_len = CNT_W'(div) + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      ld_cnt <= '0;
    end else begin
      hi_cnt <= sio_clk ? hi_cnt + CNT_W'(1) : '0;
      ld_cnt <= sio_ld  ? ld_cnt + CNT_W'(1) : '0;
    end
  end

  // R2: disabled controller keeps clock and strobe low
  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sio_clk && !sio_ld));

  // R9: data out is frozen while the shift clock is high
  assert_do_stable_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sio_do) |-> !sio_clk);

  // R10: no shift clock during the load pulse
  assert_no_clk_in_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sio_ld |-> !sio_clk);

  // R8: high phase lasts divider+1 cycles
  assert_high_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sio_clk) && run) |-> (hi_cnt == phase_len));

  // R10: load strobe lasts two phases
  assert_load_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sio_ld) && run) |-> (ld_cnt == (phase_len << 1)));

endmodule

bind serial_gpio_expander sgx_checker #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (ctl_run),
  .div     (ctl_div),
  .sio_clk (sio_clk),
  .sio_ld  (sio_ld),
  .sio_do  (sio_do)
);

// File: tb/serial_gpio_expander_tb.sv
module serial_gpio_expander_tb;

  typedef struct packed {
    logic [127:0] bits;
    logic [7:0]   len;
  } frame_t;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        sio_clk, sio_ld, sio_do, sio_di;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  serial_gpio_expander u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sio_clk   (sio_clk),
    .sio_ld    (sio_ld),
    .sio_do    (sio_do),
    .sio_di    (sio_di)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- external chain model ----------------
  logic [127:0] pat;
  logic [127:0] cap_bits;
  int           cap_len  = 0;
  int           rise_cnt = 0;
  frame_t       exp_q [$];
  string        cur_tag = "R3";

  assign sio_di = (rise_cnt < 128) ? pat[rise_cnt[6:0]] : 1'b0;

  always @(posedge sio_clk) begin
    if (cap_len < 128) cap_bits[cap_len[6:0]] = sio_do;
    cap_len  = cap_len + 1;
    rise_cnt = rise_cnt + 1;
  end

  // monitor: compare each finished frame against the scoreboard
  always @(posedge sio_ld) begin
    frame_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_checks++;
      if (cap_len != int'(e.len) || cap_bits !== e.bits) begin
        n_fail++;
        $display("FAIL %s frame: actual len=%0d bits=%h expected len=%0d bits=%h",
                 cur_tag, cap_len, cap_bits, e.len, e.bits);
      end
    end
    cap_bits = '0;
    cap_len  = 0;
    rise_cnt = 0;
  end

  // phase width measurement and data-out stability
  int   hi_run = 0, last_hi = 0, ld_run = 0, last_ld = 0, r9_bad = 0;
  logic prev_clk = 0, prev_do = 0;
  always @(negedge clk) begin
    if (sio_clk) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
    if (sio_ld) ld_run++;
    else if (ld_run != 0) begin last_ld = ld_run; ld_run = 0; end
    if (sio_clk && prev_clk && (sio_do !== prev_do)) r9_bad++;
    prev_clk = sio_clk;
    prev_do  = sio_do;
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // driver: programs a configuration, pushes expected frames, checks results
  task automatic run_case(input string tag, input logic [31:0] mask, input int bpp,
                          input int div, input logic [127:0] outv,
                          input logic [127:0] polv, input logic [127:0] chain);
    frame_t       e;
    logic [127:0] in_exp;
    logic [31:0]  d;
    int           k;
    wr(4'd0, 32'd0);
    repeat (4) @(negedge clk);
    wr(4'd2, mask);
    wr(4'd1, 32'(div));
    for (int w = 0; w < 4; w++) begin
      wr(4'(4 + w), outv[w*32 +: 32]);
      wr(4'(8 + w), polv[w*32 +: 32]);
    end
    e = '0; in_exp = '0; k = 0;
    for (int p = 0; p < 32; p++) begin
      if (mask[p]) begin
        for (int b = 0; b < bpp; b++) begin
          e.bits[k]         = outv[p*4 + b] ^ polv[p*4 + b];
          in_exp[p*4 + b]   = chain[k] ^ polv[p*4 + b];
          k++;
        end
      end
    end
    e.len = 8'(k);
    cur_tag = tag;
    pat = chain;
    cap_bits = '0; cap_len = 0; rise_cnt = 0;
    exp_q.push_back(e);
    exp_q.push_back(e);
    wr(4'd0, {29'd0, 2'(bpp - 1), 1'b1});
    @(posedge sio_ld);
    @(posedge sio_ld);
    @(negedge sio_ld);
    // R11 / R7: captured inputs, polarity applied, unstreamed bits zero
    for (int w = 0; w < 4; w++) begin
      rd(4'(12 + w), d);
      check({tag, " R11 R7 input word"}, d, in_exp[w*32 +: 32]);
    end
    if (k > 0) check("R8 high phase width", 32'(last_hi), 32'(div + 1));
    check("R10 load width", 32'(last_ld), 32'(2 * (div + 1)));
    check({tag, " R10 frames consumed"}, 32'(exp_q.size()), 32'd0);
    wr(4'd0, 32'd0);
    repeat (3) @(negedge clk);
    exp_q.delete();
    repeat (2 * (div + 1) + 6) @(negedge clk);
    check("R2 idle pins", {30'd0, sio_clk, sio_ld}, 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d;
    logic [127:0] o1, p1;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; pat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, d);  check("R1 ctrl reset", d, 32'd0);
    rd(4'd1, d);  check("R1 divider reset", d, 32'd0);
    rd(4'd2, d);  check("R1 mask reset", d, 32'hFFFF_FFFF);
    rd(4'd5, d);  check("R1 output reset", d, 32'd0);
    rd(4'd13, d); check("R1 input reset", d, 32'd0);
    check("R1 pins reset", {30'd0, sio_clk, sio_ld}, 32'd0);
    repeat (20) @(negedge clk);
    check("R2 no frame while disabled", 32'(cap_len), 32'd0);

    // R12 readback
    wr(4'd1, 32'h0000_1234); rd(4'd1, d); check("R12 divider readback", d, 32'h0000_1234);
    wr(4'd2, 32'h0F0F_00FF); rd(4'd2, d); check("R12 mask readback", d, 32'h0F0F_00FF);
    wr(4'd6, 32'hCAFE_F00D); rd(4'd6, d); check("R12 output readback", d, 32'hCAFE_F00D);
    wr(4'd9, 32'h1357_9BDF); rd(4'd9, d); check("R12 polarity readback", d, 32'h1357_9BDF);
    wr(4'd0, 32'h0000_0004); rd(4'd0, d); check("R12 ctrl readback", d, 32'h0000_0004);

    o1 = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    p1 = 128'h8000_0001_0000_00FF_A5A5_0000_0F0F_F00F;

    // R3 full stream, 4 bits per port, fastest rate
    run_case("R3", 32'hFFFF_FFFF, 4, 0, o1, '0, 128'h5A5A_F00F_1234_8765_DEAD_BEEF_0BAD_CAFE);
    // R5 two bits per port, lower 20 ports
    run_case("R5", 32'h000F_FFFF, 2, 1, o1, '0, 128'h0000_0000_0000_00AB_CDEF_0123_3C3C_9669);
    // R6 sparse ports with inversion, one bit per port
    run_case("R6", 32'h8000_0005, 1, 2, o1, p1 | 128'h1, 128'h5);
    // R4 empty mask: no bits, strobe still pulses
    run_case("R4", 32'h0000_0000, 4, 0, o1, p1, 128'hFFFF);
    // R4 checkerboard mask, three bits per port, inversion on both sides
    run_case("R4", 32'hA5A5_A5A5, 3, 3, ~o1, p1, 128'h0000_1F2E_3D4C_5B6A_7988_97A6_B5C4_D3E2);

    check("R9 data out stable while clock high", 32'(r9_bad), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule